// File: doc/BRIEF.md
# Watchpoint Comparator Bank

This block is a bank of address and cycle watchpoints for a processor debug subsystem. Each comparator holds three configuration words: a compare value, a mask width and a function word. It watches every bus access the core makes, looking at the address and the read/write direction. When an access matches, the comparator acts according to its 4-bit function code. It can raise a trace request that names the kind of packet to emit, raise a debug-event pulse, or raise a compare-match pulse. Comparator 0 can also be switched to compare its value against a free-running cycle count instead of addresses.

The function code encodes two things at once: which access directions qualify, and which action is taken. An emit-range bit in the function word turns data or PC packet requests into address packet requests for the codes where that applies. A sticky matched flag per comparator records that the comparator acted. It can be read in the function word and is cleared by reading that word. Data-value matching and comparator linking are not built, and their fields always read as zero.

Top module: `wpt_bank`

## Requirements
- R1: Register word address `{n, w}` selects comparator n (upper bits) and word w (low 2 bits). w=0 is the compare value, w=1 is the mask width (5 bits, upper bits read zero), w=2 is the function word and w=3 always reads zero. `reg_rdata` shows the addressed word combinationally. A write takes effect at the next clock edge. Reset clears every word and every output.
- R2: The function word reads back with the code in bits 3:0, emit-range in bit 5, cycle-mode in bit 7 and the matched flag in bit 24. All other bits read zero. Cycle-mode is stored only for comparator 0 and reads zero on all the others. Writes to bit 24 are ignored.
- R3: In address mode an access matches when `acc_valid` is high and the access address equals the compare value in every bit at or above bit position `mask`. The lowest `mask` bits are ignored.
- R4: Read-only codes act only when `acc_write`=0. 1100 requests a data packet (kind 1), or an address packet (kind 2) with emit-range set. 1110 requests PC+data (kind 3), or address+data (kind 4) with emit-range set. 0101 gives a debug event and 1001 gives a compare-match event.
- R5: Write-only codes act only when `acc_write`=1: 1101, 1111, 0110 and 1010 have the same meanings as 1100, 1110, 0101 and 1001 respectively.
- R6: The following codes act on either direction. 0001 requests a PC packet (kind 0), or an address packet (kind 2) with emit-range set. 0010 requests data (kind 1), or address+data (kind 4) with emit-range set. 0011 requests PC+data (kind 3). 0111 gives a debug event and 1011 gives a compare-match event.
- R7: Comparator 0 with cycle-mode set ignores accesses. It matches in any cycle where its mask is 0 and `cyc_count` equals its compare value. In that mode 0001 requests a PC packet (kind 0), 0100 gives a debug event and 1000 gives a compare-match event. Emit-range has no effect, and a nonzero mask prevents any match.
- R8: Code 0000, and any code that is not defined for the current mode, produces no pulse, no trace request and no change to the matched flag.
- R9: `dbg_evt`, `cmp_evt` and `trace_req` are registered. They are high for exactly the one cycle after the cycle whose inputs matched.
- R10: The matched flag of a comparator sets whenever that comparator acts. It stays set until a read of that comparator's function word. When a read and a new action fall in the same cycle, the flag ends up set.
- R11: When several comparators request trace in the same cycle, the lowest-numbered one wins. `trace_idx` gives its number. `trace_kind` and `trace_idx` are zero when `trace_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (clears matched flag on function read) |
| reg_addr | input | IDX_W+2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_write | input | 1 | Access direction, 1 = write |
| acc_addr | input | AW | Access address |
| cyc_count | input | AW | Cycle counter value |
| dbg_evt | output | NUM_CMP | Debug-event pulse per comparator |
| cmp_evt | output | NUM_CMP | Compare-match pulse per comparator |
| trace_req | output | 1 | Trace request pulse |
| trace_kind | output | 3 | Packet kind: 0 PC, 1 data, 2 address, 3 PC+data, 4 address+data |
| trace_idx | output | IDX_W | Comparator that raised the trace request |
| matched | output | NUM_CMP | Sticky matched flag per comparator |

## Verification
The assertions assume that a debug or compare-match pulse from comparators 1 and up, and any trace from them, can only follow a cycle with `acc_valid` high. They also assume that the only way to clear a matched flag is a read strobe aimed at that comparator's function word. This means the register strobes and address must be clean, known values every cycle. The stimulus drives all inputs as complete values at the falling edge and never leaves them unknown. Random register writes stay inside the bank, and mask widths are kept small so that random addresses near the compare values actually hit.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    typedef enum logic [2:0] {
        PKT_PC        = 3'd0,
        PKT_DATA      = 3'd1,
        PKT_ADDR      = 3'd2,
        PKT_PC_DATA   = 3'd3,
        PKT_ADDR_DATA = 3'd4
    } pkt_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_TRACE = 2'd1,
        ACT_DEBUG = 2'd2,
        ACT_MATCH = 2'd3
    } act_e;

    typedef struct packed {
        act_e act;
        pkt_e pkt;
    } hit_t;

    localparam hit_t HIT_NONE = '{act: ACT_NONE, pkt: PKT_PC};

    function automatic hit_t mk_hit(act_e a, pkt_e p);
        hit_t h;
        h.act = a;
        h.pkt = p;
        return h;
    endfunction

    // Address-mode decode: the code selects direction and action together.
    function automatic hit_t decode_addr(logic [3:0] code, logic er, logic wr);
        hit_t h;
        h = HIT_NONE;
        case (code)
            4'b1100: if (!wr) h = mk_hit(ACT_TRACE, er ? PKT_ADDR : PKT_DATA);
            4'b1110: if (!wr) h = mk_hit(ACT_TRACE, er ? PKT_ADDR_DATA : PKT_PC_DATA);
            4'b0101: if (!wr) h = mk_hit(ACT_DEBUG, PKT_PC);
            4'b1001: if (!wr) h = mk_hit(ACT_MATCH, PKT_PC);
            4'b1101: if (wr)  h = mk_hit(ACT_TRACE, er ? PKT_ADDR : PKT_DATA);
            4'b1111: if (wr)  h = mk_hit(ACT_TRACE, er ? PKT_ADDR_DATA : PKT_PC_DATA);
            4'b0110: if (wr)  h = mk_hit(ACT_DEBUG, PKT_PC);
            4'b1010: if (wr)  h = mk_hit(ACT_MATCH, PKT_PC);
            4'b0001: h = mk_hit(ACT_TRACE, er ? PKT_ADDR : PKT_PC);
            4'b0010: h = mk_hit(ACT_TRACE, er ? PKT_ADDR_DATA : PKT_DATA);
            4'b0011: h = mk_hit(ACT_TRACE, PKT_PC_DATA);
            4'b0111: h = mk_hit(ACT_DEBUG, PKT_PC);
            4'b1011: h = mk_hit(ACT_MATCH, PKT_PC);
            default: h = HIT_NONE;
        endcase
        return h;
    endfunction

    // Cycle-mode decode: emit-range plays no part here.
    function automatic hit_t decode_cycle(logic [3:0] code);
        hit_t h;
        case (code)
            4'b0001: h = mk_hit(ACT_TRACE, PKT_PC);
            4'b0100: h = mk_hit(ACT_DEBUG, PKT_PC);
            4'b1000: h = mk_hit(ACT_MATCH, PKT_PC);
            default: h = HIT_NONE;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/wpt_cmp_unit.sv
module wpt_cmp_unit
    import wpt_pkg::*;
#(
    parameter int AW     = 32,
    parameter int MASK_W = 5
) (
    input  logic [AW-1:0]     cfg_comp,
    input  logic [MASK_W-1:0] cfg_mask,
    input  logic [3:0]        cfg_code,
    input  logic              cfg_er,
    input  logic              cfg_cyc,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [AW-1:0]     acc_addr,
    input  logic [AW-1:0]     cyc_count,
    output hit_t              hit
);

    logic [AW-1:0] keep;
    logic          addr_eq;
    logic          cyc_eq;

    always_comb begin
        keep    = {AW{1'b1}} << cfg_mask;
        addr_eq = acc_valid && ((acc_addr & keep) == (cfg_comp & keep));
        cyc_eq  = (cfg_mask == '0) && (cyc_count == cfg_comp);
        if (cfg_cyc) begin
            hit = cyc_eq ? decode_cycle(cfg_code) : HIT_NONE;
        end else begin
            hit = addr_eq ? decode_addr(cfg_code, cfg_er, acc_write) : HIT_NONE;
        end
    end

endmodule

// File: rtl/wpt_bank.sv
module wpt_bank
    import wpt_pkg::*;
#(
    parameter int   NUM_CMP = 4,
    parameter int   AW      = 32,
    localparam int  IDX_W   = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
    localparam int  REG_AW  = IDX_W + 2,
    localparam int  MASK_W  = $clog2(AW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [AW-1:0]      acc_addr,
    input  logic [AW-1:0]      cyc_count,
    output logic [NUM_CMP-1:0] dbg_evt,
    output logic [NUM_CMP-1:0] cmp_evt,
    output logic               trace_req,
    output logic [2:0]         trace_kind,
    output logic [IDX_W-1:0]   trace_idx,
    output logic [NUM_CMP-1:0] matched
);

    typedef struct packed {
        logic [NUM_CMP-1:0][AW-1:0]     comp;
        logic [NUM_CMP-1:0][MASK_W-1:0] mask;
        logic [NUM_CMP-1:0][3:0]        code;
        logic [NUM_CMP-1:0]             er;
        logic                           cyc0;
        logic [NUM_CMP-1:0]             flag;
        logic [NUM_CMP-1:0]             dbg;
        logic [NUM_CMP-1:0]             cme;
        logic                           trv;
        logic [2:0]                     trk;
        logic [IDX_W-1:0]               trc_idx;
    } state_t;

    state_t st_d, st_q;
    hit_t   hit [NUM_CMP];

    logic [IDX_W-1:0] reg_sel;
    logic [1:0]       reg_word;

    assign reg_sel  = reg_addr[REG_AW-1:2];
    assign reg_word = reg_addr[1:0];

    // Only comparator 0 gets the cycle-count path; the rest see it tied off.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        if (g == 0) begin : g_cyc
            wpt_cmp_unit #(.AW(AW), .MASK_W(MASK_W)) u_unit (
                .cfg_comp  (st_q.comp[g]),
                .cfg_mask  (st_q.mask[g]),
                .cfg_code  (st_q.code[g]),
                .cfg_er    (st_q.er[g]),
                .cfg_cyc   (st_q.cyc0),
                .acc_valid (acc_valid),
                .acc_write (acc_write),
                .acc_addr  (acc_addr),
                .cyc_count (cyc_count),
                .hit       (hit[g])
            );
        end else begin : g_addr
            wpt_cmp_unit #(.AW(AW), .MASK_W(MASK_W)) u_unit (
                .cfg_comp  (st_q.comp[g]),
                .cfg_mask  (st_q.mask[g]),
                .cfg_code  (st_q.code[g]),
                .cfg_er    (st_q.er[g]),
                .cfg_cyc   (1'b0),
                .acc_valid (acc_valid),
                .acc_write (acc_write),
                .acc_addr  (acc_addr),
                .cyc_count ({AW{1'b0}}),
                .hit       (hit[g])
            );
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.dbg     = '0;
        st_d.cme     = '0;
        st_d.trv     = 1'b0;
        st_d.trk     = 3'd0;
        st_d.trc_idx = '0;
        for (int i = 0; i < NUM_CMP; i++) begin
            if (reg_wr_en && reg_sel == IDX_W'(i)) begin
                case (reg_word)
                    2'd0: st_d.comp[i] = reg_wdata[AW-1:0];
                    2'd1: st_d.mask[i] = reg_wdata[MASK_W-1:0];
                    2'd2: begin
                        st_d.code[i] = reg_wdata[3:0];
                        st_d.er[i]   = reg_wdata[5];
                        if (i == 0) st_d.cyc0 = reg_wdata[7];
                    end
                    default: ;
                endcase
            end
            if (reg_rd_en && reg_sel == IDX_W'(i) && reg_word == 2'd2) begin
                st_d.flag[i] = 1'b0;
            end
            case (hit[i].act)
                ACT_DEBUG: st_d.dbg[i] = 1'b1;
                ACT_MATCH: st_d.cme[i] = 1'b1;
                default: ;
            endcase
            if (hit[i].act != ACT_NONE) st_d.flag[i] = 1'b1;
        end
        // Walk downward so the lowest-numbered requester is written last.
        for (int i = NUM_CMP - 1; i >= 0; i--) begin
            if (hit[i].act == ACT_TRACE) begin
                st_d.trv     = 1'b1;
                st_d.trk     = hit[i].pkt;
                st_d.trc_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CMP; i++) begin
            if (reg_sel == IDX_W'(i)) begin
                case (reg_word)
                    2'd0: reg_rdata = 32'(st_q.comp[i]);
                    2'd1: reg_rdata = 32'(st_q.mask[i]);
                    2'd2: begin
                        reg_rdata[3:0] = st_q.code[i];
                        reg_rdata[5]   = st_q.er[i];
                        reg_rdata[7]   = (i == 0) ? st_q.cyc0 : 1'b0;
                        reg_rdata[24]  = st_q.flag[i];
                    end
                    default: reg_rdata = '0;
                endcase
            end
        end
    end

    assign dbg_evt    = st_q.dbg;
    assign cmp_evt    = st_q.cme;
    assign trace_req  = st_q.trv;
    assign trace_kind = st_q.trk;
    assign trace_idx  = st_q.trc_idx;
    assign matched    = st_q.flag;

endmodule

// File: rtl/wpt_bank_chk.sv
module wpt_bank_chk #(
    parameter int  NUM_CMP = 4,
    localparam int IDX_W   = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
    localparam int REG_AW  = IDX_W + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_rd_en,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [31:0]        reg_rdata,
    input logic               acc_valid,
    input logic [NUM_CMP-1:0] dbg_evt,
    input logic [NUM_CMP-1:0] cmp_evt,
    input logic               trace_req,
    input logic [2:0]         trace_kind,
    input logic [IDX_W-1:0]   trace_idx,
    input logic [NUM_CMP-1:0] matched
);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr[1:0] == 2'd3) |-> (reg_rdata == 32'd0));

    assert_func_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr[1:0] == 2'd2) |->
            (reg_rdata[31:25] == '0 && reg_rdata[23:8] == '0 && !reg_rdata[6] && !reg_rdata[4]));

    assert_trace_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_req |-> (trace_kind == 3'd0 && trace_idx == '0));

    assert_trace_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trace_req |-> (trace_kind <= 3'd4));

    assert_trace_needs_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_req && trace_idx != '0) |-> $past(acc_valid));

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_chk
        assert_evt_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (dbg_evt[g] || cmp_evt[g]) |-> matched[g]);

        assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(matched[g]) && !$past(reg_rd_en && reg_addr == {IDX_W'(g), 2'b10}))
                |-> matched[g]);

        if (g > 0) begin : g_addr_only
            assert_evt_needs_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (dbg_evt[g] || cmp_evt[g]) |-> $past(acc_valid));
        end
    end

endmodule

bind wpt_bank wpt_bank_chk #(.NUM_CMP(NUM_CMP)) u_wpt_bank_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd_en  (reg_rd_en),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .acc_valid  (acc_valid),
    .dbg_evt    (dbg_evt),
    .cmp_evt    (cmp_evt),
    .trace_req  (trace_req),
    .trace_kind (trace_kind),
    .trace_idx  (trace_idx),
    .matched    (matched)
);

// File: tb/wpt_bank_bench.sv
module wpt_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int IW = 2;
    localparam int RAW = IW + 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr_en = 1'b0;
    logic            reg_rd_en = 1'b0;
    logic [RAW-1:0]  reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            acc_valid = 1'b0;
    logic            acc_write = 1'b0;
    logic [31:0]     acc_addr = '0;
    logic [31:0]     cyc_count = '0;
    logic [N-1:0]    dbg_evt, cmp_evt, matched;
    logic            trace_req;
    logic [2:0]      trace_kind;
    logic [IW-1:0]   trace_idx;

    wpt_bank #(.NUM_CMP(N), .AW(32)) u_wpt_bank (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .cyc_count(cyc_count),
        .dbg_evt(dbg_evt), .cmp_evt(cmp_evt), .trace_req(trace_req),
        .trace_kind(trace_kind), .trace_idx(trace_idx), .matched(matched)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Bench-side view of the configuration, kept from the requirements.
    logic [31:0] m_comp [N];
    logic [4:0]  m_mask [N];
    logic [3:0]  m_code [N];
    logic        m_er   [N];
    logic        m_cyc0;
    logic [N-1:0] m_matched;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Result encoding in the bench: [4:3] action 0 none/1 trace/2 debug/3 match, [2:0] packet kind.
    function automatic logic [4:0] exp_one(int i, bit av, bit aw, logic [31:0] aa, logic [31:0] cc);
        logic [31:0] keep;
        logic [3:0]  c;
        bit          ro, wo;
        c = m_code[i];
        if (i == 0 && m_cyc0) begin
            if (m_mask[0] != 5'd0 || cc != m_comp[0]) return 5'd0;
            if (c == 4'b0001) return {2'd1, 3'd0};
            if (c == 4'b0100) return {2'd2, 3'd0};
            if (c == 4'b1000) return {2'd3, 3'd0};
            return 5'd0;
        end
        keep = 32'hFFFF_FFFF << m_mask[i];
        if (!av || ((aa & keep) != (m_comp[i] & keep))) return 5'd0;
        ro = (c == 4'hC) || (c == 4'hE) || (c == 4'h5) || (c == 4'h9);
        wo = (c == 4'hD) || (c == 4'hF) || (c == 4'h6) || (c == 4'hA);
        if (ro && aw) return 5'd0;
        if (wo && !aw) return 5'd0;
        case (c)
            4'hC, 4'hD: return {2'd1, m_er[i] ? 3'd2 : 3'd1};
            4'hE, 4'hF: return {2'd1, m_er[i] ? 3'd4 : 3'd3};
            4'h1:       return {2'd1, m_er[i] ? 3'd2 : 3'd0};
            4'h2:       return {2'd1, m_er[i] ? 3'd4 : 3'd1};
            4'h3:       return {2'd1, 3'd3};
            4'h5, 4'h6, 4'h7: return {2'd2, 3'd0};
            4'h9, 4'hA, 4'hB: return {2'd3, 3'd0};
            default:    return 5'd0;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(logic [RAW-1:0] a);
        int i;
        logic [31:0] r;
        i = int'(a[RAW-1:2]);
        r = '0;
        case (a[1:0])
            2'd0: r = m_comp[i];
            2'd1: r = {27'd0, m_mask[i]};
            2'd2: begin
                r[3:0] = m_code[i];
                r[5]   = m_er[i];
                r[7]   = (i == 0) ? m_cyc0 : 1'b0;
                r[24]  = m_matched[i];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    // One clock of stimulus; rdata checked before the edge, outputs after it.
    task automatic step(input bit wr, input bit rd, input logic [RAW-1:0] a, input logic [31:0] wd,
                        input bit av, input bit aw, input logic [31:0] aa, input logic [31:0] cc,
                        input string tag);
        logic [N-1:0] e_dbg, e_cmp, e_flag;
        logic         e_trv;
        logic [2:0]   e_trk;
        logic [IW-1:0] e_idx;
        logic [4:0]   r;
        int           sel;
        reg_wr_en = wr; reg_rd_en = rd; reg_addr = a; reg_wdata = wd;
        acc_valid = av; acc_write = aw; acc_addr = aa; cyc_count = cc;
        #1;
        if (rd) chk(reg_rdata == exp_rd(a), {tag, " rdata"}, reg_rdata, exp_rd(a));
        e_dbg = '0; e_cmp = '0; e_trv = 1'b0; e_trk = 3'd0; e_idx = '0;
        e_flag = m_matched;
        sel = int'(a[RAW-1:2]);
        if (rd && a[1:0] == 2'd2) e_flag[sel] = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            r = exp_one(i, av, aw, aa, cc);
            if (r[4:3] != 2'd0) e_flag[i] = 1'b1;
            if (r[4:3] == 2'd2) e_dbg[i] = 1'b1;
            if (r[4:3] == 2'd3) e_cmp[i] = 1'b1;
            if (r[4:3] == 2'd1) begin e_trv = 1'b1; e_trk = r[2:0]; e_idx = IW'(i); end
        end
        @(posedge clk);
        #1;
        if (wr) begin
            case (a[1:0])
                2'd0: m_comp[sel] = wd;
                2'd1: m_mask[sel] = wd[4:0];
                2'd2: begin
                    m_code[sel] = wd[3:0];
                    m_er[sel]   = wd[5];
                    if (sel == 0) m_cyc0 = wd[7];
                end
                default: ;
            endcase
        end
        m_matched = e_flag;
        @(negedge clk);
        #1;
        chk(dbg_evt == e_dbg, {tag, " dbg_evt"}, 32'(dbg_evt), 32'(e_dbg));
        chk(cmp_evt == e_cmp, {tag, " cmp_evt"}, 32'(cmp_evt), 32'(e_cmp));
        chk({trace_req, trace_kind, trace_idx} == {e_trv, e_trk, e_idx}, {tag, " trace"},
            32'({trace_req, trace_kind, trace_idx}), 32'({e_trv, e_trk, e_idx}));
        chk(matched == e_flag, {tag, " matched"}, 32'(matched), 32'(e_flag));
    endtask

    task automatic wr_reg(input int c, input int w, input logic [31:0] d, input string tag);
        step(1'b1, 1'b0, {IW'(c), 2'(w)}, d, 1'b0, 1'b0, 32'd0, 32'hFFFF_0000, tag);
    endtask

    task automatic rd_reg(input int c, input int w, input string tag);
        step(1'b0, 1'b1, {IW'(c), 2'(w)}, 32'd0, 1'b0, 1'b0, 32'd0, 32'hFFFF_0000, tag);
    endtask

    task automatic access(input bit aw, input logic [31:0] aa, input string tag);
        step(1'b0, 1'b0, '0, 32'd0, 1'b1, aw, aa, 32'hFFFF_0000, tag);
    endtask

    task automatic cycle_only(input logic [31:0] cc, input string tag);
        step(1'b0, 1'b0, '0, 32'd0, 1'b0, 1'b0, 32'd0, cc, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_comp[i] = '0; m_mask[i] = '0; m_code[i] = '0; m_er[i] = 1'b0;
        end
        m_cyc0 = 1'b0;
        m_matched = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state of outputs
        chk({dbg_evt, cmp_evt, trace_req, trace_kind, trace_idx, matched} == '0,
            "R1 reset outputs", 32'({dbg_evt, cmp_evt, trace_req, matched}), 32'd0);
        for (int c = 0; c < N; c++)
            for (int w = 0; w < 4; w++) rd_reg(c, w, "R1 reset readback");

        // R1/R2: field widths and read-only / reserved bits
        wr_reg(0, 2, 32'hFFFF_FFFF, "R2 write func0");
        rd_reg(0, 2, "R2 func0 fields");
        wr_reg(1, 2, 32'hFFFF_FFFF, "R2 write func1");
        rd_reg(1, 2, "R2 func1 no cycle bit");
        wr_reg(0, 1, 32'hFFFF_FFFF, "R1 mask width");
        rd_reg(0, 1, "R1 mask readback");
        wr_reg(2, 3, 32'hFFFF_FFFF, "R1 reserved write");
        rd_reg(2, 3, "R1 reserved reads zero");
        wr_reg(0, 2, 32'h0, "R1 clear func0");
        wr_reg(1, 2, 32'h0, "R1 clear func1");
        wr_reg(0, 1, 32'h0, "R1 clear mask0");

        // R3: masked address compare
        wr_reg(1, 0, 32'h0000_1000, "R3 setup");
        wr_reg(1, 1, 32'd4, "R3 setup");
        wr_reg(1, 2, 32'h2, "R3 setup");
        access(1'b0, 32'h0000_100F, "R3 low bits ignored");
        access(1'b1, 32'h0000_1010, "R3 bit above mask differs");
        rd_reg(1, 2, "R10 read clears flag");
        rd_reg(1, 2, "R10 flag cleared");

        // R4: read-only codes
        wr_reg(2, 0, 32'h0000_2000, "R4 setup");
        wr_reg(2, 2, 32'h5, "R4 setup");
        access(1'b0, 32'h0000_2000, "R4 read debug");
        access(1'b1, 32'h0000_2000, "R4 write ignored");
        wr_reg(2, 2, 32'h2E, "R4 setup");
        access(1'b0, 32'h0000_2000, "R4 addr+data");
        wr_reg(2, 2, 32'hC, "R4 setup");
        access(1'b0, 32'h0000_2000, "R4 data");

        // R5: write-only codes
        wr_reg(2, 2, 32'hA, "R5 setup");
        access(1'b1, 32'h0000_2000, "R5 write match event");
        access(1'b0, 32'h0000_2000, "R5 read ignored");
        wr_reg(2, 2, 32'h2D, "R5 setup");
        access(1'b1, 32'h0000_2000, "R5 address packet");

        // R6: either-direction codes
        wr_reg(3, 0, 32'h0000_3000, "R6 setup");
        wr_reg(3, 2, 32'h21, "R6 setup");
        access(1'b0, 32'h0000_3000, "R6 address on read");
        access(1'b1, 32'h0000_3000, "R6 address on write");
        wr_reg(3, 2, 32'h23, "R6 setup");
        access(1'b1, 32'h0000_3000, "R6 pc+data");

        // R11: lowest index wins
        wr_reg(1, 0, 32'h0000_3000, "R11 setup");
        wr_reg(1, 1, 32'd0, "R11 setup");
        wr_reg(1, 2, 32'h1, "R11 setup");
        access(1'b0, 32'h0000_3000, "R11 arbitration");
        chk(trace_idx == IW'(1), "R11 trace_idx", 32'(trace_idx), 32'd1);

        // R10: set wins over clear-on-read in the same cycle
        step(1'b0, 1'b1, {IW'(3), 2'd2}, 32'd0, 1'b1, 1'b0, 32'h0000_3000, 32'd0, "R10 set wins");
        chk(matched[3] == 1'b1, "R10 flag after read+hit", 32'(matched[3]), 32'd1);

        // R7: cycle-count mode on comparator 0
        wr_reg(0, 0, 32'd50, "R7 setup");
        wr_reg(0, 2, 32'h84, "R7 setup");
        cycle_only(32'd50, "R7 debug on count");
        cycle_only(32'd51, "R7 no hit");
        access(1'b0, 32'd50, "R7 accesses ignored");
        wr_reg(0, 2, 32'hA1, "R7 setup");
        cycle_only(32'd50, "R7 pc sample, emit-range ignored");
        wr_reg(0, 1, 32'd1, "R7 nonzero mask");
        cycle_only(32'd50, "R7 mask blocks match");
        wr_reg(0, 1, 32'd0, "R7 restore");
        wr_reg(0, 2, 32'h88, "R7 setup");
        cycle_only(32'd50, "R7 match event");
        wr_reg(0, 2, 32'h82, "R8 setup");
        cycle_only(32'd50, "R8 undefined cycle code");

        // R8: disabled and undefined codes
        wr_reg(0, 2, 32'h0, "R8 setup");
        rd_reg(0, 2, "R8 clear flag");
        wr_reg(0, 0, 32'h0000_4000, "R8 setup");
        access(1'b0, 32'h0000_4000, "R8 code zero");
        wr_reg(0, 2, 32'h4, "R8 setup");
        access(1'b1, 32'h0000_4000, "R8 code 0100 in address mode");
        wr_reg(0, 2, 32'h8, "R8 setup");
        access(1'b0, 32'h0000_4000, "R8 code 1000 in address mode");

        // R9: random mix; every cycle checked against the bench model
        for (int n = 0; n < 4000; n++) begin
            bit          wr, rd, av, aw;
            int          c, w;
            logic [31:0] wd, aa, cc;
            c  = int'($urandom_range(N - 1, 0));
            w  = int'($urandom_range(3, 0));
            wr = ($urandom_range(99, 0) < 20);
            rd = !wr && ($urandom_range(99, 0) < 20);
            case (w)
                0: wd = 32'h1000 * $urandom_range(3, 0) + $urandom_range(15, 0);
                1: wd = $urandom_range(5, 0);
                2: wd = {$urandom} & 32'h0100_00BF;
                default: wd = $urandom;
            endcase
            av = ($urandom_range(99, 0) < 70);
            aw = $urandom_range(1, 0) == 1;
            aa = 32'h1000 * $urandom_range(3, 0) + $urandom_range(31, 0);
            cc = ($urandom_range(1, 0) == 1) ? m_comp[0] : 32'($urandom_range(40, 0));
            step(wr, rd, {IW'(c), 2'(w)}, wd, av, aw, aa, cc, "R9 random");
        end

        finish_run();
    end

endmodule